// File: doc/BRIEF.md
# Symmetric Filter Tap-Step Sequencer

This block sequences one octave job on a folded multiply-accumulate engine. The engine evaluates four 41-tap linear-phase filters: three band filters and one half-band decimation filter. All four read the same input history. Each coefficient set is symmetric, so one pass over 21 tap positions covers a whole filter. In each position the two mirrored samples are fetched once and shared by all four coefficient reads. The sequencer steps a tap counter and a step counter and turns the pair into data-memory reads and writes and coefficient reads. It also handles the flow-control handshakes with the input and output buffers. The arithmetic is done elsewhere.

A job is started with an octave number and an iteration base, which is the data-memory offset of the newest sample of that octave. Each octave owns its own circular region of data memory. Data addresses count backwards from the base and wrap inside the region. Octave 0 takes a fresh input sample at the start of the job. Every job except the one for the top octave writes its decimated output into the region of the next octave. The current step is exported so that the arithmetic unit can line up a delayed copy with the data coming back from memory.

Top module: `tapseq_top`

## Requirements
- R1: While reset is held, `busy`, `tap`, `step`, every strobe, `mem_addr` and `coef_addr` are 0.
- R2: With `busy` low, a high `start` on a clock edge latches `oct_i` and `base_i`. From the next cycle `busy` is high, with `tap`=0 and `step`=0. While `busy` is high, `start` has no effect.
- R3: Taps 1 to 19 run steps 0,1,2,3,4,5 in that order, one cycle each, and then the tap counter advances. Step 0 reads data at distance 40−tap from the base. Step 1 reads data at distance tap. Steps 2 to 5 read the coefficient of filter step−2 (filter 0 is the decimation filter).
- R4: The centre tap 20 has no step 1. It runs steps 0,2,3,4,5,6,7, and its only data read is at distance 20.
- R5: At tap 0, step 1 of an octave-0 job, the sequencer waits while `rdy_in` is low, with no memory access. In the cycle `rdy_in` is high it writes the input to offset `base` (`mem_we`=1) and pulses `in_ack` for exactly that cycle.
- R6: At tap 0, step 1 of a job for an octave above 0, the sequencer does an ordinary read at offset `base` without waiting, and `in_ack` stays low.
- R7: Step 6 waits while `rdy_out` is high. In the cycle `rdy_out` is low, `res_enq` pulses and the decimated output is written to region oct+1 at offset base>>1. For the top octave (7) no write is made, but `res_enq` still pulses.
- R8: `mem_addr` = oct×64 + ((base − distance) mod 64) for reads and for the input write. `coef_addr` = filter×21 + tap. Both are 0 when no access is made.
- R9: Step 7 lasts one cycle with `done` high. In the following cycle `busy` is low.
- R10: `step` shows the current step while `busy` is high and is 0 when idle. `mem_re` and `mem_we` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request a job (taken only when idle) |
| oct_i | input | 3 | Octave number of the job |
| base_i | input | 6 | Iteration base offset within the octave region |
| rdy_in | input | 1 | Input sample available |
| rdy_out | input | 1 | Output buffer occupied (results must wait) |
| busy | output | 1 | Job in progress |
| tap | output | 5 | Current tap position 0..20 |
| step | output | 3 | Current step 0..7 |
| mem_re | output | 1 | Data memory read |
| mem_we | output | 1 | Data memory write |
| mem_addr | output | 9 | Data memory address {octave, offset} |
| coef_re | output | 1 | Coefficient read |
| coef_addr | output | 7 | Coefficient address filter×21+tap |
| in_ack | output | 1 | Input sample taken this cycle |
| res_enq | output | 1 | Band results and decimated output delivered this cycle |
| done | output | 1 | Final synchronisation step of the job |

## Verification
Two conditions are hard to reach from the ports. One is a wait on `rdy_in` at tap 0, which only happens in an octave-0 job. The other is a wait on `rdy_out` at step 6, which only happens about 125 cycles into a job. Both have to line up with the sequencer's progress. The bench drives both ready lines from a free-running pseudo-random pattern during most jobs, so stalls of various lengths fall on both wait points. It covers octave 0 and octave 7, and it uses bases near 0 and 63 so that the backward addresses wrap. In one job it raises `start` while the sequencer is busy, to show that the request is ignored.

// File: rtl/tapseq_pkg.sv
package tapseq_pkg;

  typedef struct packed {
    logic [2:0] st;
    logic       adv_tap;
    logic       fin;
  } nxt_t;

  // Step program: normal taps 0..5, centre tap skips 1 and appends 6,7.
  function automatic nxt_t step_after(input logic [2:0] st, input logic at_last);
    nxt_t n;
    n = '0;
    case (st)
      3'd0: n.st = at_last ? 3'd2 : 3'd1;
      3'd1, 3'd2, 3'd3, 3'd4: n.st = st + 3'd1;
      3'd5: begin
        if (at_last) n.st = 3'd6;
        else begin
          n.st = 3'd0;
          n.adv_tap = 1'b1;
        end
      end
      3'd6: n.st = 3'd7;
      default: begin
        n.st = 3'd0;
        n.fin = 1'b1;
      end
    endcase
    return n;
  endfunction

  // Distance back from the base for the two data loads of a tap.
  function automatic int data_dist(input int st, input int tp, input int ntap);
    return (st == 0) ? (ntap - 1 - tp) : tp;
  endfunction

  // Coefficient ROM index: filter-major, tap-minor.
  function automatic int coef_index(input int st, input int tp, input int half);
    return (st - 2) * half + tp;
  endfunction

endpackage

// File: rtl/tapseq_ctrl.sv
module tapseq_ctrl #(
  parameter int HALF    = 21,
  parameter int TAP_W   = 5,
  parameter int OCT_W   = 3,
  parameter int DEPTH_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [OCT_W-1:0]   oct_i,
  input  logic [DEPTH_W-1:0] base_i,
  input  logic               rdy_in,
  input  logic               rdy_out,
  output logic               busy,
  output logic [TAP_W-1:0]   tap,
  output logic [2:0]         step,
  output logic [OCT_W-1:0]   oct_q,
  output logic [DEPTH_W-1:0] base_q
);
  import tapseq_pkg::*;

  localparam logic [TAP_W-1:0] LAST = TAP_W'(HALF - 1);

  logic in_wait, out_wait, hold, at_last;
  nxt_t nx;

  assign at_last  = (tap == LAST);
  assign in_wait  = busy && (tap == '0) && (step == 3'd1) && (oct_q == '0) && !rdy_in;
  assign out_wait = busy && (step == 3'd6) && rdy_out;
  assign hold     = in_wait || out_wait;
  assign nx       = step_after(step, at_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tap    <= '0;
      step   <= '0;
      oct_q  <= '0;
      base_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy   <= 1'b1;
        tap    <= '0;
        step   <= '0;
        oct_q  <= oct_i;
        base_q <= base_i;
      end
    end else if (!hold) begin
      step <= nx.st;
      if (nx.adv_tap) tap <= tap + TAP_W'(1);
      if (nx.fin) begin
        busy <= 1'b0;
        tap  <= '0;
      end
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && tap == '0 && step == 3'd0));

  // R5
  in_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wait |=> (busy && $stable(step) && $stable(tap)));

  // R7
  out_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_wait |=> (busy && step == 3'd6));

  // R4
  centre_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == 3'd1) |-> (tap != LAST));

endmodule

// File: rtl/tapseq_decode.sv
module tapseq_decode #(
  parameter int NTAP    = 41,
  parameter int HALF    = 21,
  parameter int OCT_N   = 8,
  parameter int TAP_W   = 5,
  parameter int OCT_W   = 3,
  parameter int DEPTH_W = 6,
  parameter int COEF_W  = 7
) (
  input  logic                     busy,
  input  logic [TAP_W-1:0]         tap,
  input  logic [2:0]               step,
  input  logic [OCT_W-1:0]         oct_q,
  input  logic [DEPTH_W-1:0]       base_q,
  input  logic                     rdy_in,
  input  logic                     rdy_out,
  output logic                     mem_re,
  output logic                     mem_we,
  output logic [OCT_W+DEPTH_W-1:0] mem_addr,
  output logic                     coef_re,
  output logic [COEF_W-1:0]        coef_addr,
  output logic                     in_ack,
  output logic                     res_enq,
  output logic                     done
);
  import tapseq_pkg::*;

  localparam logic [OCT_W-1:0] TOP_OCT = OCT_W'(OCT_N - 1);

  logic [DEPTH_W-1:0] rd_off;
  logic [DEPTH_W-1:0] dec_off;
  logic [OCT_W-1:0]   nxt_oct;
  logic               take_new;

  assign rd_off   = base_q - DEPTH_W'(data_dist(int'(step), int'(tap), NTAP));
  assign dec_off  = base_q >> 1;
  assign nxt_oct  = oct_q + OCT_W'(1);
  assign take_new = (tap == '0) && (oct_q == '0);

  always_comb begin
    mem_re    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    coef_re   = 1'b0;
    coef_addr = '0;
    in_ack    = 1'b0;
    res_enq   = 1'b0;
    done      = 1'b0;
    if (busy) begin
      case (step)
        3'd0: begin
          mem_re   = 1'b1;
          mem_addr = {oct_q, rd_off};
        end
        3'd1: begin
          if (take_new) begin
            if (rdy_in) begin
              mem_we   = 1'b1;
              in_ack   = 1'b1;
              mem_addr = {oct_q, base_q};
            end
          end else begin
            mem_re   = 1'b1;
            mem_addr = {oct_q, rd_off};
          end
        end
        3'd2, 3'd3, 3'd4, 3'd5: begin
          coef_re   = 1'b1;
          coef_addr = COEF_W'(coef_index(int'(step), int'(tap), HALF));
        end
        3'd6: begin
          if (!rdy_out) begin
            res_enq = 1'b1;
            if (oct_q != TOP_OCT) begin
              mem_we   = 1'b1;
              mem_addr = {nxt_oct, dec_off};
            end
          end
        end
        default: done = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/tapseq_top.sv
module tapseq_top #(
  parameter int NTAP    = 41,
  parameter int OCT_N   = 8,
  parameter int DEPTH_W = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  oct_i,
  input  logic [5:0]  base_i,
  input  logic        rdy_in,
  input  logic        rdy_out,
  output logic        busy,
  output logic [4:0]  tap,
  output logic [2:0]  step,
  output logic        mem_re,
  output logic        mem_we,
  output logic [8:0]  mem_addr,
  output logic        coef_re,
  output logic [6:0]  coef_addr,
  output logic        in_ack,
  output logic        res_enq,
  output logic        done
);
  localparam int HALF   = (NTAP + 1) / 2;
  localparam int TAP_W  = $clog2(HALF);
  localparam int OCT_W  = $clog2(OCT_N);
  localparam int COEF_W = $clog2(4 * HALF);

  logic [OCT_W-1:0]   oct_q;
  logic [DEPTH_W-1:0] base_q;

  tapseq_ctrl #(
    .HALF(HALF), .TAP_W(TAP_W), .OCT_W(OCT_W), .DEPTH_W(DEPTH_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .oct_i(oct_i), .base_i(base_i),
    .rdy_in(rdy_in), .rdy_out(rdy_out), .busy(busy), .tap(tap), .step(step),
    .oct_q(oct_q), .base_q(base_q)
  );

  tapseq_decode #(
    .NTAP(NTAP), .HALF(HALF), .OCT_N(OCT_N), .TAP_W(TAP_W), .OCT_W(OCT_W),
    .DEPTH_W(DEPTH_W), .COEF_W(COEF_W)
  ) u_dec (
    .busy(busy), .tap(tap), .step(step), .oct_q(oct_q), .base_q(base_q),
    .rdy_in(rdy_in), .rdy_out(rdy_out), .mem_re(mem_re), .mem_we(mem_we),
    .mem_addr(mem_addr), .coef_re(coef_re), .coef_addr(coef_addr),
    .in_ack(in_ack), .res_enq(res_enq), .done(done)
  );

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_re, mem_we, coef_re}));

  // R5
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ack |=> !in_ack);

endmodule

// File: tb/tapseq_top_tb.sv
module tapseq_top_tb;
  localparam int HALF = 21;
  localparam int DEPTH = 64;
  localparam int TOPO = 7;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, rdy_in = 1'b0, rdy_out = 1'b0;
  logic [2:0] oct_i = '0;
  logic [5:0] base_i = '0;
  logic busy, mem_re, mem_we, coef_re, in_ack, res_enq, done;
  logic [4:0] tap;
  logic [2:0] step;
  logic [8:0] mem_addr;
  logic [6:0] coef_addr;

  int n_chk = 0, n_fail = 0;
  int m_busy = 0, m_tap = 0, m_oct = 0, m_base = 0;
  int m_q[$];
  int mode = 1;
  logic [15:0] lfsr = 16'hACE1;

  tapseq_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .oct_i(oct_i), .base_i(base_i),
    .rdy_in(rdy_in), .rdy_out(rdy_out), .busy(busy), .tap(tap), .step(step),
    .mem_re(mem_re), .mem_we(mem_we), .mem_addr(mem_addr), .coef_re(coef_re),
    .coef_addr(coef_addr), .in_ack(in_ack), .res_enq(res_enq), .done(done)
  );

  always #5 clk = ~clk;

  task automatic chk(input string req, input string nm, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, nm, act, exp);
    end
  endtask

  function automatic int wrap(input int v);
    return ((v % DEPTH) + DEPTH) % DEPTH;
  endfunction

  function automatic void load_prog(input int t);
    m_q.delete();
    m_q.push_back(0);
    if (t != HALF - 1) m_q.push_back(1);
    for (int k = 2; k <= 5; k++) m_q.push_back(k);
    if (t == HALF - 1) begin
      m_q.push_back(6);
      m_q.push_back(7);
    end
  endfunction

  // reference model, advanced on every edge
  always @(posedge clk) begin
    if (!rst_n) m_busy = 0;
    else if (m_busy == 0) begin
      if (start) begin
        m_busy = 1; m_tap = 0; m_oct = int'(oct_i); m_base = int'(base_i);
        load_prog(0);
      end
    end else begin
      int cur;
      bit stall;
      cur = m_q[0];
      stall = (cur == 1 && m_tap == 0 && m_oct == 0 && !rdy_in) || (cur == 6 && rdy_out);
      if (!stall) begin
        void'(m_q.pop_front());
        if (m_q.size() == 0) begin
          if (m_tap == HALF - 1) m_busy = 0;
          else begin
            m_tap++;
            load_prog(m_tap);
          end
        end
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "tap/step", int'(tap) + int'(step), 0);
      chk("R1", "strobes", int'({mem_re, mem_we, coef_re, in_ack, res_enq, done}), 0);
      chk("R1", "addrs", int'(mem_addr) + int'(coef_addr), 0);
    end else begin
      int es, et, re, we, ad, cr, ca, ak, eq, dn;
      string tg;
      es = m_busy ? m_q[0] : 0;
      et = m_busy ? m_tap : 0;
      re = 0; we = 0; ad = 0; cr = 0; ca = 0; ak = 0; eq = 0; dn = 0;
      tg = (et == HALF - 1) ? "R4" : "R3";
      if (m_busy != 0) begin
        case (es)
          0: begin re = 1; ad = m_oct * DEPTH + wrap(m_base - (40 - m_tap)); end
          1: begin
            if (m_tap == 0 && m_oct == 0) begin
              tg = "R5";
              if (rdy_in) begin we = 1; ak = 1; ad = m_base; end
            end else begin
              if (m_tap == 0) tg = "R6";
              re = 1; ad = m_oct * DEPTH + wrap(m_base - m_tap);
            end
          end
          2, 3, 4, 5: begin cr = 1; ca = (es - 2) * HALF + m_tap; end
          6: begin
            tg = "R7";
            if (!rdy_out) begin
              eq = 1;
              if (m_oct < TOPO) begin we = 1; ad = (m_oct + 1) * DEPTH + m_base / 2; end
            end
          end
          default: begin tg = "R9"; dn = 1; end
        endcase
      end
      chk("R2", "busy", int'(busy), m_busy);
      chk("R10", "step", int'(step), es);
      chk(tg, "tap", int'(tap), et);
      chk(tg, "mem_re", int'(mem_re), re);
      chk(tg, "mem_we", int'(mem_we), we);
      chk("R8", "mem_addr", int'(mem_addr), ad);
      chk(tg, "coef_re", int'(coef_re), cr);
      chk("R8", "coef_addr", int'(coef_addr), ca);
      chk("R5", "in_ack", int'(in_ack), ak);
      chk("R7", "res_enq", int'(res_enq), eq);
      chk("R9", "done", int'(done), dn);
      chk("R10", "re_we_excl", int'(mem_re & mem_we), 0);
    end
  end

  // ready-line pattern
  initial begin
    forever begin
      @(posedge clk); #2;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (mode == 1) begin rdy_in = 1'b1; rdy_out = 1'b0; end
      else begin rdy_in = lfsr[3] & lfsr[7]; rdy_out = lfsr[1] | lfsr[9]; end
    end
  end

  task automatic run_job(input int o, input int b, input int md, input bit noisy);
    @(posedge clk); #2;
    while (m_busy != 0) begin @(posedge clk); #2; end
    mode = md;
    start = 1'b1; oct_i = 3'(o); base_i = 6'(b);
    @(posedge clk); #2;
    start = 1'b0;
    if (noisy) begin
      repeat (10) @(posedge clk);
      #2;
      start = 1'b1; oct_i = 3'd5; base_i = 6'd9;   // R2: ignored while busy
      repeat (3) @(posedge clk);
      #2;
      start = 1'b0;
    end
    while (m_busy != 0) begin @(posedge clk); #2; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    run_job(0, 5, 1, 1'b0);   // R3 R5 no stalls, wraps
    run_job(0, 40, 0, 1'b0);  // R5 R7 random stalls
    run_job(3, 50, 0, 1'b1);  // R2 R6
    run_job(7, 63, 0, 1'b0);  // R7 top octave
    run_job(1, 0, 1, 1'b0);   // R8 wrap from zero
    run_job(0, 63, 0, 1'b0);
    repeat (4) @(posedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule